// File: doc/BRIEF.md
# XTS Block-Stream Sequencer with Ciphertext Stealing

This block runs one XTS encrypt or decrypt pass over a message of any byte length from 16 bytes upward. A start strobe latches the initial vector, the byte count and the direction. The sequencer then asks an external block cipher to encrypt the initial vector under the tweak key, which gives the first tweak. It pulls the message one 128-bit word at a time with a read strobe. Each block is whitened with the tweak, sent through the cipher under the data key, and whitened again. The tweak is doubled in GF(2^128) after every block.

When the length is not a multiple of 16, the last full block and the trailing partial block are handled with ciphertext stealing. The full block is ciphered first. The bytes it leaves over pad the partial block, which is then ciphered with the following tweak and emitted in the second-to-last output slot. The head of the first result becomes the short final word. On decryption the two tweaks of that pair are used in the opposite order. The cipher rounds sit outside this block and are reached only through a request/acknowledge port.

Top module: `xts_stream_seq`

## Requirements
- R1: When `start` is high while `busy` is low, `iv`, `byte_count` and `decrypt` are captured in that cycle, and `busy` is high from the next cycle until the operation ends.
- R2: `start` seen while `busy` is high is ignored. The running operation's outputs are unchanged.
- R3: Each operation makes exactly one cipher request with `cph_key_sel`=1 (1 selects the tweak key, 0 the data key) and `cph_decrypt`=0, carrying the captured IV. It comes before any read.
- R4: `rd` is high for exactly ceil(byte_count/16) cycles per operation, each marking one consumed `din` word. Message byte j of a word sits at bits [8j+7:8j].
- R5: Block k (k from 0) uses tweak T_k, where T_0 is the tweak-key cipher output and T_(k+1) is T_k shifted left one bit, with 0x87 XORed into bits [7:0] when bit 127 of T_k was 1.
- R6: For a length that is a multiple of 16, output word k is C(din_k xor T_k) xor T_k. C is the data-key cipher, forward when `decrypt`=0 (`cph_decrypt`=0) and inverse when `decrypt`=1 (`cph_decrypt`=1).
- R7: Encryption with m = byte_count mod 16 nonzero and n full blocks: X = C(P_(n-1) xor T_(n-1)) xor T_(n-1). The partial input is padded with bytes m..15 of X, and the padded block ciphered with T_n is emitted as word n-1. X is emitted as word n.
- R8: Decryption with m nonzero: the last full input is processed with T_n to give Y. The partial input padded with bytes m..15 of Y is processed with T_(n-1) and emitted as word n-1. Y is emitted as word n. Bytes m..15 of the partial input word are ignored.
- R9: In the short final output word, bytes m..15 are zero.
- R10: `finish` is a one-cycle pulse that coincides with the last `dout_valid`. `busy` is low in the following cycle.
- R11: `start` in the cycle after `finish` begins a new operation that completes correctly.
- R12: `dout_valid` is high for exactly ceil(byte_count/16) cycles per operation, one per output word, in message order.
- R13: `cph_req` stays high with `cph_din`, `cph_key_sel` and `cph_decrypt` stable until the one-cycle `cph_ack`. `cph_dout` is taken in the `cph_ack` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation |
| decrypt | input | 1 | Direction: 1 decrypt, 0 encrypt |
| iv | input | 128 | Initial vector for the tweak |
| byte_count | input | 16 | Message length in bytes, at least 16 |
| rd | output | 1 | Read strobe; `din` must be valid in this cycle |
| din | input | 128 | Message word |
| dout_valid | output | 1 | `dout` holds an output word |
| dout | output | 128 | Output word |
| busy | output | 1 | Operation in progress |
| finish | output | 1 | Last cycle of the operation |
| cph_req | output | 1 | Cipher request |
| cph_key_sel | output | 1 | 1 tweak key, 0 data key |
| cph_decrypt | output | 1 | 1 inverse cipher |
| cph_din | output | 128 | Cipher input block |
| cph_ack | input | 1 | Cipher result valid (one cycle) |
| cph_dout | input | 128 | Cipher result |

## Verification
A wrong first tweak or a wrong doubling step corrupts the first or the next output word. That word appears about three cycles after its read, because each block waits on its own cipher response. A wrong phase decode or a wrong tweak swap leaves every earlier word correct and corrupts only the last two words, so stealing needs lengths whose remainder is both small and large, in both directions. A stuck state machine shows at once as a missing `finish`, a `busy` that stays high, or a read count that differs from ceil(length/16).

// File: rtl/xts_seq_pkg.sv
package xts_seq_pkg;
  localparam int BLK_W = 128;
  localparam int BYTES = BLK_W / 8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_TWEAK, ST_READ, ST_CIPH, ST_TAIL, ST_DONE
  } seq_state_e;

  typedef enum logic [1:0] {
    PH_PLAIN, PH_STEAL_A, PH_STEAL_B
  } blk_phase_e;

  // Multiply by alpha in GF(2^128): shift up, fold the carry into the low byte.
  function automatic logic [BLK_W-1:0] gf_double(input logic [BLK_W-1:0] t);
    logic [BLK_W-1:0] r;
    r = {t[BLK_W-2:0], 1'b0};
    if (t[BLK_W-1]) r[7:0] = r[7:0] ^ 8'h87;
    return r;
  endfunction

  // All-ones over message bytes 0..m-1, zero above.
  function automatic logic [BLK_W-1:0] byte_keep_mask(input logic [3:0] m);
    logic [BLK_W-1:0] r;
    for (int j = 0; j < BYTES; j++) r[j*8 +: 8] = (j < int'(m)) ? 8'hFF : 8'h00;
    return r;
  endfunction
endpackage

// File: rtl/xts_tweak_unit.sv
module xts_tweak_unit import xts_seq_pkg::*; (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [BLK_W-1:0] load_val,
  input  logic             advance,
  output logic [BLK_W-1:0] tw_cur,
  output logic [BLK_W-1:0] tw_next
);
  assign tw_next = gf_double(tw_cur);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       tw_cur <= '0;
    else if (load)    tw_cur <= load_val;
    else if (advance) tw_cur <= tw_next;
  end

  // R5: the tweak is seeded once, before any block uses it
  a_r5_no_seed_and_step: assert property (@(posedge clk) disable iff (!rst_n)
    !(load && advance));
endmodule

// File: rtl/xts_block_tracker.sv
module xts_block_tracker import xts_seq_pkg::*; #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init,
  input  logic [CNT_W-1:0] count_in,
  input  logic             take,
  output blk_phase_e       phase_now,
  output blk_phase_e       phase_q,
  output logic             last_q,
  output logic [3:0]       rem_q
);
  localparam int FULL_W = CNT_W - 4;
  localparam int IDX_W  = CNT_W - 3;

  logic [FULL_W-1:0] nfull_q;
  logic [IDX_W-1:0]  idx_q, nfull_ext, nwords;
  logic              steal, last_now;

  assign steal     = (rem_q != 4'd0);
  assign nfull_ext = {1'b0, nfull_q};
  assign nwords    = nfull_ext + {{(IDX_W-1){1'b0}}, steal};
  assign last_now  = !steal && (idx_q == nwords - 1'b1);

  always_comb begin
    phase_now = PH_PLAIN;
    if (steal && idx_q == nfull_ext - 1'b1) phase_now = PH_STEAL_A;
    else if (steal && idx_q == nfull_ext)   phase_now = PH_STEAL_B;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nfull_q <= '0; rem_q <= '0; idx_q <= '0; phase_q <= PH_PLAIN; last_q <= 1'b0;
    end else if (init) begin
      nfull_q <= count_in[CNT_W-1:4];
      rem_q   <= count_in[3:0];
      idx_q   <= '0;
      phase_q <= PH_PLAIN;
      last_q  <= 1'b0;
    end else if (take) begin
      idx_q   <= idx_q + 1'b1;
      phase_q <= phase_now;
      last_q  <= last_now;
    end
  end

  // R4: never read past ceil(length/16) words
  a_r4_read_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (idx_q < nwords));
endmodule

// File: rtl/xts_out_stage.sv
module xts_out_stage import xts_seq_pkg::*; (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             emit,
  input  logic             emit_last,
  input  logic             mask_en,
  input  logic [3:0]       rem,
  input  logic [BLK_W-1:0] val,
  output logic [BLK_W-1:0] dout,
  output logic             dout_valid,
  output logic             finish
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout <= '0; dout_valid <= 1'b0; finish <= 1'b0;
    end else begin
      dout_valid <= emit;
      finish     <= emit && emit_last;
      if (emit) dout <= mask_en ? (val & byte_keep_mask(rem)) : val;
    end
  end

  // R10: finish marks an output word and lasts one cycle
  a_r10_finish_on_word: assert property (@(posedge clk) disable iff (!rst_n)
    finish |-> dout_valid);
  a_r10_finish_single: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> !finish);
endmodule

// File: rtl/xts_stream_seq.sv
module xts_stream_seq #(
  parameter int CNT_W = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          decrypt,
  input  logic [127:0]  iv,
  input  logic [CNT_W-1:0] byte_count,
  output logic          rd,
  input  logic [127:0]  din,
  output logic          dout_valid,
  output logic [127:0]  dout,
  output logic          busy,
  output logic          finish,
  output logic          cph_req,
  output logic          cph_key_sel,
  output logic          cph_decrypt,
  output logic [127:0]  cph_din,
  input  logic          cph_ack,
  input  logic [127:0]  cph_dout
);
  import xts_seq_pkg::*;

  seq_state_e       state_q;
  logic             dec_q;
  logic [BLK_W-1:0] iv_q, blk_q, hold_q;
  logic [BLK_W-1:0] tw_cur, tw_next, tw_use, res, keep, merged;
  blk_phase_e       phase_now, phase_q;
  logic             last_q;
  logic [3:0]       rem_q;

  // Named events
  logic accept, tweak_done, ciph_done, use_next, emit, emit_last, in_tail;
  assign accept     = start && (state_q == ST_IDLE);
  assign tweak_done = (state_q == ST_TWEAK) && cph_ack;
  assign ciph_done  = (state_q == ST_CIPH) && cph_ack;
  assign in_tail    = (state_q == ST_TAIL);
  assign use_next   = (phase_q == PH_STEAL_A && dec_q) || (phase_q == PH_STEAL_B && !dec_q);
  assign emit       = (ciph_done && phase_q != PH_STEAL_A) || in_tail;
  assign emit_last  = (ciph_done && phase_q == PH_PLAIN && last_q) || in_tail;

  assign busy        = (state_q != ST_IDLE);
  assign rd          = (state_q == ST_READ);
  assign cph_req     = (state_q == ST_TWEAK) || (state_q == ST_CIPH);
  assign cph_key_sel = (state_q == ST_TWEAK);
  assign cph_decrypt = (state_q == ST_CIPH) && dec_q;
  assign tw_use      = use_next ? tw_next : tw_cur;
  assign cph_din     = (state_q == ST_TWEAK) ? iv_q : (blk_q ^ tw_use);
  assign res         = cph_dout ^ tw_use;
  assign keep        = byte_keep_mask(rem_q);
  assign merged      = (din & keep) | (hold_q & ~keep);

  xts_block_tracker #(.CNT_W(CNT_W)) u_track (
    .clk(clk), .rst_n(rst_n), .init(accept), .count_in(byte_count), .take(rd),
    .phase_now(phase_now), .phase_q(phase_q), .last_q(last_q), .rem_q(rem_q));

  xts_tweak_unit u_tweak (
    .clk(clk), .rst_n(rst_n), .load(tweak_done), .load_val(cph_dout),
    .advance(ciph_done && phase_q == PH_PLAIN), .tw_cur(tw_cur), .tw_next(tw_next));

  xts_out_stage u_out (
    .clk(clk), .rst_n(rst_n), .emit(emit), .emit_last(emit_last), .mask_en(in_tail),
    .rem(rem_q), .val(in_tail ? hold_q : res), .dout(dout), .dout_valid(dout_valid),
    .finish(finish));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE; dec_q <= 1'b0; iv_q <= '0; blk_q <= '0; hold_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          iv_q    <= iv;
          dec_q   <= decrypt;
          state_q <= ST_TWEAK;
        end
        ST_TWEAK: if (cph_ack) state_q <= ST_READ;
        ST_READ: begin
          blk_q   <= (phase_now == PH_STEAL_B) ? merged : din;
          state_q <= ST_CIPH;
        end
        ST_CIPH: if (cph_ack) begin
          unique case (phase_q)
            PH_STEAL_A: begin hold_q <= res; state_q <= ST_READ; end
            PH_STEAL_B: state_q <= ST_TAIL;
            default:    state_q <= last_q ? ST_DONE : ST_READ;
          endcase
        end
        ST_TAIL: state_q <= ST_DONE;
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R1: accepted start raises busy next cycle
  a_r1_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  // R10: busy drops right after finish
  a_r10_idle_after_finish: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> !busy);
  // R13: a pending cipher request holds its operands
  a_r13_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (cph_req && !cph_ack) |=> (cph_req && $stable(cph_din) && $stable(cph_key_sel)
                               && $stable(cph_decrypt)));
  // R3: the first request after start targets the tweak key
  a_r3_tweak_first: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (cph_req && cph_key_sel && !cph_decrypt));
  // R4: reading and a cipher request never overlap
  a_r4_read_not_waiting: assert property (@(posedge clk) disable iff (!rst_n)
    rd |-> !cph_ack);
endmodule

// File: tb/tb_xts_stream_seq.sv
module tb_xts_stream_seq;
  localparam logic [127:0] KT = 128'h0f1e2d3c_4b5a6978_8796a5b4_c3d2e1f0;
  localparam logic [127:0] KD = 128'h13579bdf_2468ace0_fdb97531_0eca8642;
  localparam int NT = 9;
  localparam int T_CNT  [NT] = '{16, 48, 31, 37, 17, 93, 16, 100, 64};
  localparam bit T_DEC  [NT] = '{0, 0, 0, 1, 0, 0, 1, 1, 1};
  localparam int T_SEED [NT] = '{3, 5, 7, 11, 13, 17, 19, 23, 29};

  logic clk = 0, rst_n = 0, start = 0, decrypt = 0;
  logic [127:0] iv = '0;
  logic [15:0] byte_count = '0;
  logic rd, dout_valid, busy, finish, cph_req, cph_key_sel, cph_decrypt;
  logic [127:0] din, dout, cph_din, cph_dout;
  logic cph_ack;

  always #4 clk = ~clk;

  xts_stream_seq dut (.clk(clk), .rst_n(rst_n), .start(start), .decrypt(decrypt),
    .iv(iv), .byte_count(byte_count), .rd(rd), .din(din), .dout_valid(dout_valid),
    .dout(dout), .busy(busy), .finish(finish), .cph_req(cph_req),
    .cph_key_sel(cph_key_sel), .cph_decrypt(cph_decrypt), .cph_din(cph_din),
    .cph_ack(cph_ack), .cph_dout(cph_dout));

  int checks = 0, fails = 0;
  logic clr = 1;
  bit use_mem = 0;
  int seed_cur = 0;
  logic [127:0] mem [16];
  logic [127:0] cap [16];
  logic [127:0] exp_w [16];
  int rd_n = 0, out_n = 0, fin_idx = -1, twk_n = 0, lat = 0;
  logic [127:0] twk_in = '0;
  bit req_drop = 0;

  function automatic logic [127:0] gen(int s, int i);
    logic [127:0] r;
    for (int j = 0; j < 4; j++)
      r[j*32 +: 32] = 32'(s) * 32'h9E3779B1 ^ 32'(i + 1) * 32'h85EBCA6B ^ 32'(j + 3) * 32'hC2B2AE35;
    return r;
  endfunction
  function automatic logic [127:0] e_twk(logic [127:0] x); return {x[120:0], x[127:121]} ^ KT; endfunction
  function automatic logic [127:0] e_dat(logic [127:0] x); return {x[122:0], x[127:123]} ^ KD; endfunction
  function automatic logic [127:0] d_dat(logic [127:0] y);
    logic [127:0] z; z = y ^ KD; return {z[4:0], z[127:5]};
  endfunction
  // alpha multiply via a 129-bit product reduced by the field polynomial
  function automatic logic [127:0] dbl(logic [127:0] x);
    logic [128:0] p; p = {x, 1'b0};
    if (p[128]) p = p ^ {1'b1, 120'b0, 8'h87};
    return p[127:0];
  endfunction
  function automatic logic [127:0] keepm(int m);
    logic [127:0] r = '0;
    for (int b = 0; b < m; b++) r[b*8 +: 8] = 8'hFF;
    return r;
  endfunction
  function automatic logic [127:0] xf(bit dec, logic [127:0] x, logic [127:0] t);
    return (dec ? d_dat(x ^ t) : e_dat(x ^ t)) ^ t;
  endfunction

  assign din = use_mem ? mem[rd_n[3:0]] : gen(seed_cur, rd_n);

  // Block-cipher responder, two-cycle latency
  always @(posedge clk) begin
    cph_ack <= 1'b0;
    if (clr) begin twk_n <= 0; lat <= 0; end
    else if (lat != 0 && !cph_req) req_drop <= 1'b1;
    if (!clr && cph_req && !cph_ack) begin
      if (lat == 1) begin
        cph_ack  <= 1'b1; lat <= 0;
        cph_dout <= cph_key_sel ? e_twk(cph_din) : (cph_decrypt ? d_dat(cph_din) : e_dat(cph_din));
        if (cph_key_sel) begin twk_n <= twk_n + 1; twk_in <= cph_din; end
      end else lat <= lat + 1;
    end
  end
  always @(posedge clk) if (clr) rd_n <= 0; else if (rd) rd_n <= rd_n + 1;
  always @(negedge clk) begin
    if (clr) begin out_n <= 0; fin_idx <= -1; end
    else if (dout_valid) begin
      cap[out_n[3:0]] <= dout;
      if (finish) fin_idx <= out_n;
      out_n <= out_n + 1;
    end
  end

  task automatic chk(bit ok, string req, logic [127:0] act, logic [127:0] expv);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s act=%h exp=%h", req, act, expv); end
  endtask

  task automatic build_exp(int cnt, bit dec, logic [127:0] ivv, output int nw);
    int n, m; logic [127:0] t [17]; logic [127:0] p [17]; logic [127:0] x, pad;
    n = cnt / 16; m = cnt % 16; nw = n + (m != 0 ? 1 : 0);
    t[0] = e_twk(ivv);
    for (int i = 0; i < nw; i++) begin
      if (i > 0) t[i] = dbl(t[i-1]);
      p[i] = use_mem ? mem[i] : gen(seed_cur, i);
    end
    for (int i = 0; i < nw; i++) exp_w[i] = xf(dec, p[i], t[i]);
    if (m != 0) begin
      x = xf(dec, p[n-1], dec ? t[n] : t[n-1]);
      pad = (p[n] & keepm(m)) | (x & ~keepm(m));
      exp_w[n-1] = xf(dec, pad, dec ? t[n-1] : t[n]);
      exp_w[n]   = x & keepm(m);
    end
  endtask

  task automatic run_op(int cnt, bit dec, int seed, bit poke, output bit ok);
    int nw, e0; logic [127:0] ivv; bit done = 0;
    ivv = gen(seed + 100, 9);
    seed_cur = seed;
    build_exp(cnt, dec, ivv, nw);
    e0 = fails;
    start = 1; clr = 1; decrypt = dec; iv = ivv; byte_count = 16'(cnt);
    @(negedge clk); #1;
    start = 0; clr = 0; decrypt = ~dec; iv = '1; byte_count = 16'd16;
    chk(busy === 1'b1, "R1 busy after start", 128'(busy), 128'd1);
    for (int c = 0; c < 3000 && !done; c++) begin
      @(negedge clk); #1;
      if (poke && c == 4) start = 1;
      if (poke && c == 5) start = 0;
      if (finish) done = 1;
    end
    chk(done, "R10 finish seen", 128'(done), 128'd1);
    @(negedge clk); #1;
    chk(busy === 1'b0, "R10 busy low after finish", 128'(busy), 128'd0);
    chk(twk_n == 1 && twk_in == ivv, "R3 tweak request", twk_in, ivv);
    chk(rd_n == nw, "R4 read count", 128'(rd_n), 128'(nw));
    chk(out_n == nw, "R12 output count", 128'(out_n), 128'(nw));
    chk(fin_idx == nw - 1, "R10 finish on last word", 128'(fin_idx), 128'(nw - 1));
    for (int k = 0; k < nw && k < 16; k++)
      chk(cap[k] === exp_w[k], (cnt % 16 == 0) ? "R5 R6 word" : (dec ? "R8 word" : "R7 word"),
          cap[k], exp_w[k]);
    if (cnt % 16 != 0)
      chk((cap[nw-1] & ~keepm(cnt % 16)) == '0, "R9 tail zero", cap[nw-1], exp_w[nw-1]);
    if (poke) chk(fails == e0, "R2 start while busy ignored", 128'(fails - e0), 128'd0);
    ok = (fails == e0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    bit ok, b2b = 1;
    repeat (3) @(negedge clk);
    #1;
    chk(!busy && !dout_valid && !finish && !rd && !cph_req, "R1 reset idle",
        {123'd0, busy, dout_valid, finish, rd, cph_req}, 128'd0);
    rst_n = 1;
    @(negedge clk); #1;
    // Vector table, each entry started the cycle after the previous finish
    for (int i = 0; i < NT; i++) begin
      run_op(T_CNT[i], T_DEC[i], T_SEED[i], 1'b0, ok);
      if (i > 0 && !ok) b2b = 0;
    end
    chk(b2b, "R11 back-to-back operations", 128'(b2b), 128'd1);
    // Directed: start pulses mid-operation
    run_op(45, 1'b0, 41, 1'b1, ok);
    // Directed: round trip through stealing recovers the plaintext
    run_op(37, 1'b0, 77, 1'b0, ok);
    for (int k = 0; k < 3; k++) mem[k] = cap[k];
    use_mem = 1;
    run_op(37, 1'b1, 77, 1'b0, ok);
    use_mem = 0;
    for (int k = 0; k < 3; k++)
      chk(cap[k] === (gen(77, k) & (k == 2 ? keepm(5) : '1)), "R8 round trip",
          cap[k], gen(77, k) & (k == 2 ? keepm(5) : '1));
    chk(!req_drop, "R13 request held until ack", 128'(req_drop), 128'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule